// File: doc/BRIEF.md
# Host Control and Interrupt Gating

This block sits between the host bus and the packet engines of a network controller. Through a two-bit register address the host writes a control byte and a transmit detect mask, and reads back a control status byte, the transmit outcome byte and a receive acknowledge byte. The block decides who owns the packet buffer: the host, the transmitter, the receiver, or both in loopback. It tracks the transmit and receive busy flags and latches each transmit outcome reported by the transmit engine. It counts consecutive collisions and drives the host interrupt and DMA request lines. Both lines pass through one shared enable bit.

The buffer owner is a four-state machine. `BM_HOST` (code 0) gives the buffer to the host. `BM_XMIT` (code 1) sends one frame. `BM_RECV` (code 2) waits for one frame. `BM_LOOP` (code 3) does both at once.

Every write of the control byte moves the machine to the written code; that transition is called *select*. One transition happens with no write, called *rollover*: a successful transmission in `BM_XMIT` moves the machine to `BM_RECV` and arms the receiver. The transmit engine reports collision, success and underflow as one-cycle pulses. The receive engine pulses when it has kept a frame. The DMA controller pulses terminal count.

Top module: `hostctl_gate`

## Requirements
- R1: Writing the control byte (address 0) with bit 7 set clears every control, status, mask, pending and counter register. The block then stays cleared until a control write with bit 7 at 0. That release write's other fields are discarded. While held, all events and transmit-mask writes are ignored, and address 0 reads 0x80.
- R2: While the enable bit (control bit 6) is 0, `irq` and `drq` are 0 whatever else is pending.
- R3: Writing control bit 5 as 1 requests DMA, and `drq` = enable AND request AND NOT done. A `dma_tc` pulse while requested and not done sets done (address 0 read bit 4) and raises the interrupt. Writing bit 5 as 0 clears request and done.
- R4: Address 1 reads the transmit outcome in bits 3:0: bit 0 underflow, bit 1 collision, bit 2 sixteen consecutive collisions, bit 3 ready for a new frame. It is reloaded only by an accepted event: collision gives 0x02 (or 0x06), success gives 0x08, underflow gives 0x01.
- R5: A modulo-16 counter counts consecutive accepted collisions. The 16th sets outcome bit 2 and wraps the counter. A success clears the counter.
- R6: Address 0 read bit 7 (transmit busy) is 1 in `BM_HOST` and `BM_RECV` and after selecting `BM_XMIT` or `BM_LOOP`. It falls on a collision or underflow, and on a success in `BM_LOOP`.
- R7: A success in `BM_XMIT` rolls over to `BM_RECV`: address 0 bits 3:2 read 2 and bit 0 (receive busy) reads 1.
- R8: Receive busy rises when `BM_RECV` or `BM_LOOP` is entered from another state. It falls on `rx_frame_kept`, which also sets a receive pending flag. Reading address 2 returns that flag in bit 0 and clears it.
- R9: The byte written to address 1 is a detect mask over the outcome bits. An outcome raises the transmit pending flag only if it has a bit in common with the mask. Reading address 1 clears that flag.
- R10: Transmit events are accepted only in `BM_XMIT` or `BM_LOOP` while transmit busy is 1. Otherwise the outcome byte and interrupt stay unchanged.
- R11: `fcs_corrupt` follows control bit 0, and `buf_ctl` carries the state code.
- R12: `irq` = enable AND (transmit pending OR receive pending OR DMA done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 transmit, 2 receive acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reads at 1 and 2 have side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address |
| tx_collision | input | 1 | Transmit engine: collision pulse |
| tx_success | input | 1 | Transmit engine: frame sent pulse |
| tx_underflow | input | 1 | Transmit engine: underflow pulse |
| rx_frame_kept | input | 1 | Receive engine: frame kept pulse |
| dma_tc | input | 1 | DMA controller terminal count pulse |
| irq | output | 1 | Host interrupt request |
| drq | output | 1 | Host DMA request |
| buf_ctl | output | 2 | Current buffer owner code |
| fcs_corrupt | output | 1 | Ask transmitter to send a bad FCS |
| soft_reset | output | 1 | Software reset hold is active |

## Verification
The main sweep runs every 4-bit detect mask against each of the three transmit outcomes, with the enable bit both on and off. It tells the masking rule apart from the enable gate and from the rollover that only success causes. A run of 17 collisions, then a success, then 16 more collisions shows the sixteenth-collision flag firing exactly on the 16th, and shows that success clears the count. Events in host mode, DMA completion with the enable off, and writes made during the reset hold are each checked at the ports for having no effect.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int REG_W = 8;
    localparam int ADR_W = 2;

    typedef enum logic [1:0] {
        BM_HOST = 2'd0,
        BM_XMIT = 2'd1,
        BM_RECV = 2'd2,
        BM_LOOP = 2'd3
    } bufmode_e;

    localparam logic [ADR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADR_W-1:0] A_TX   = 2'd1;
    localparam logic [ADR_W-1:0] A_RXAK = 2'd2;

    localparam int C_RESET = 7;
    localparam int C_EN    = 6;
    localparam int C_DMA   = 5;
    localparam int C_MODEH = 3;
    localparam int C_MODEL = 2;
    localparam int C_FCS   = 0;
endpackage

// File: rtl/hc_bufmode.sv
module hc_bufmode
    import hc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       mode_wr,
    input  logic [1:0] mode_new,
    input  logic       ev_coll,
    input  logic       ev_success,
    input  logic       ev_under,
    input  logic       rx_kept,
    input  logic       rx_ack,
    output bufmode_e   state,
    output logic       tx_busy,
    output logic       rx_busy,
    output logic       tx_active,
    output logic       rx_pend
);
    bufmode_e st_q, st_n;
    logic     txb_q, txb_n, rxb_q, rxb_n, rxp_q, rxp_n;
    logic     any_ev;

    assign any_ev    = ev_coll | ev_success | ev_under;
    assign tx_active = ((st_q == BM_XMIT) || (st_q == BM_LOOP)) && txb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BM_HOST;
            txb_q <= 1'b1;
            rxb_q <= 1'b0;
            rxp_q <= 1'b0;
        end else if (clr) begin
            st_q  <= BM_HOST;
            txb_q <= 1'b1;
            rxb_q <= 1'b0;
            rxp_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            txb_q <= txb_n;
            rxb_q <= rxb_n;
            rxp_q <= rxp_n;
        end
    end

    always_comb begin
        st_n = st_q;
        if (mode_wr) begin
            st_n = bufmode_e'(mode_new);
        end else begin
            unique case (st_q)
                BM_HOST: st_n = BM_HOST;
                BM_XMIT: if (tx_active && ev_success) st_n = BM_RECV;
                BM_RECV: st_n = BM_RECV;
                BM_LOOP: st_n = BM_LOOP;
            endcase
        end

        if (st_n == BM_HOST || st_n == BM_RECV)  txb_n = 1'b1;
        else if (st_n != st_q)                   txb_n = 1'b1;
        else if (tx_active && any_ev)            txb_n = 1'b0;
        else                                     txb_n = txb_q;

        if (st_n == BM_HOST || st_n == BM_XMIT)  rxb_n = 1'b0;
        else if (st_n != st_q)                   rxb_n = 1'b1;
        else if (rxb_q && rx_kept)               rxb_n = 1'b0;
        else                                     rxb_n = rxb_q;

        if (rxb_q && rx_kept)                    rxp_n = 1'b1;
        else if (rx_ack)                         rxp_n = 1'b0;
        else                                     rxp_n = rxp_q;
    end

    assign state   = st_q;
    assign tx_busy = txb_q;
    assign rx_busy = rxb_q;
    assign rx_pend = rxp_q;

    // R7: success while transmitting hands the buffer to the receiver
    p_rollover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BM_XMIT && tx_active && ev_success && !mode_wr && !clr)
        |=> (st_q == BM_RECV && rxb_q && txb_q));

    // R6: host ownership always reports transmit busy
    p_host_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BM_HOST) |-> txb_q);
endmodule

// File: rtl/hc_txstat.sv
module hc_txstat #(
    parameter int COLL_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ev_valid,
    input  logic       ev_coll,
    input  logic       ev_success,
    input  logic       ev_under,
    input  logic       mask_wr,
    input  logic [3:0] mask_new,
    input  logic       stat_rd,
    output logic [3:0] stat,
    output logic       pend
);
    localparam int CW = (COLL_LIMIT > 1) ? $clog2(COLL_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(COLL_LIMIT - 1);

    logic [CW-1:0] cnt_q, cnt_n;
    logic [3:0]    stat_q, stat_n, mask_q;
    logic          pend_q, load;

    always_comb begin
        load   = ev_valid && (ev_coll || ev_under || ev_success);
        cnt_n  = cnt_q;
        stat_n = stat_q;
        if (ev_valid) begin
            if (ev_coll) begin
                stat_n = {2'b00, 1'b1, 1'b0};
                if (cnt_q == LAST) begin
                    stat_n[2] = 1'b1;
                    cnt_n     = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end else if (ev_under) begin
                stat_n = 4'b0001;
            end else if (ev_success) begin
                stat_n = 4'b1000;
                cnt_n  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stat_q <= '0;
            mask_q <= '0;
            pend_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            stat_q <= '0;
            mask_q <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            stat_q <= stat_n;
            if (mask_wr) mask_q <= mask_new;
            if (load && |(stat_n & mask_q)) pend_q <= 1'b1;
            else if (stat_rd)               pend_q <= 1'b0;
        end
    end

    assign stat = stat_q;
    assign pend = pend_q;

    // R5: the last collision of a run flags sixteen collisions
    p_c16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_coll && cnt_q == LAST && !clr) |=> (stat_q[2] && stat_q[1]));

    // R5: success restarts the consecutive count
    p_succ_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_success && !ev_coll && !ev_under && !clr) |=> (cnt_q == '0 && stat_q == 4'b1000));
endmodule

// File: rtl/hc_dma.sv
module hc_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req_wr,
    input  logic req_new,
    input  logic en,
    input  logic tc,
    output logic req,
    output logic done,
    output logic drq
);
    logic req_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (clr) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (req_wr) req_q <= req_new;
            if (req_wr && !req_new)          done_q <= 1'b0;
            else if (req_q && !done_q && tc) done_q <= 1'b1;
        end
    end

    assign req  = req_q;
    assign done = done_q;
    assign drq  = en & req_q & ~done_q;

    // R3: terminal count during an open request marks completion
    p_tc_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !done_q && tc && !req_wr && !clr) |=> (done_q && !drq));
endmodule

// File: rtl/hostctl_gate.sv
module hostctl_gate
    import hc_pkg::*;
#(
    parameter int COLL_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADR_W-1:0] reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tx_collision,
    input  logic             tx_success,
    input  logic             tx_underflow,
    input  logic             rx_frame_kept,
    input  logic             dma_tc,
    output logic             irq,
    output logic             drq,
    output logic [1:0]       buf_ctl,
    output logic             fcs_corrupt,
    output logic             soft_reset
);
    logic       hold_q, en_q, fcs_q;
    logic       ctrl_wr, clr, live_wr;
    bufmode_e   state;
    logic       tx_busy, rx_busy, tx_active, rx_pend;
    logic [3:0] tx_stat;
    logic       tx_pend, dma_req, dma_done;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign clr     = hold_q | (ctrl_wr & reg_wdata[C_RESET]);
    assign live_wr = ctrl_wr & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            en_q   <= 1'b0;
            fcs_q  <= 1'b0;
        end else begin
            if (ctrl_wr) hold_q <= reg_wdata[C_RESET];
            if (clr) begin
                en_q  <= 1'b0;
                fcs_q <= 1'b0;
            end else if (ctrl_wr) begin
                en_q  <= reg_wdata[C_EN];
                fcs_q <= reg_wdata[C_FCS];
            end
        end
    end

    hc_bufmode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .mode_wr    (live_wr),
        .mode_new   (reg_wdata[C_MODEH:C_MODEL]),
        .ev_coll    (tx_collision),
        .ev_success (tx_success),
        .ev_under   (tx_underflow),
        .rx_kept    (rx_frame_kept),
        .rx_ack     (reg_rd && reg_addr == A_RXAK),
        .state      (state),
        .tx_busy    (tx_busy),
        .rx_busy    (rx_busy),
        .tx_active  (tx_active),
        .rx_pend    (rx_pend)
    );

    hc_txstat #(.COLL_LIMIT(COLL_LIMIT)) u_txs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .ev_valid   (tx_active),
        .ev_coll    (tx_collision),
        .ev_success (tx_success),
        .ev_under   (tx_underflow),
        .mask_wr    (reg_wr && reg_addr == A_TX),
        .mask_new   (reg_wdata[3:0]),
        .stat_rd    (reg_rd && reg_addr == A_TX),
        .stat       (tx_stat),
        .pend       (tx_pend)
    );

    hc_dma u_dma (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .req_wr  (live_wr),
        .req_new (reg_wdata[C_DMA]),
        .en      (en_q),
        .tc      (dma_tc),
        .req     (dma_req),
        .done    (dma_done),
        .drq     (drq)
    );

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {tx_busy, en_q, dma_req, dma_done, state, 1'b0, rx_busy};
            A_TX:    reg_rdata = {4'b0000, tx_stat};
            A_RXAK:  reg_rdata = {7'b0, rx_pend};
            default: reg_rdata = '0;
        endcase
    end

    assign irq         = en_q & (tx_pend | rx_pend | dma_done);
    assign buf_ctl     = state;
    assign fcs_corrupt = fcs_q;
    assign soft_reset  = hold_q;

    // R1: during the reset hold nothing is requested and the buffer is the host's
    p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (!irq && !drq && tx_busy && state == BM_HOST));

    // R2: a request line never rises in a cycle after the enable is cleared
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_wr && !reg_wdata[C_EN]) |=> (!irq && !drq));
endmodule

// File: tb/test_hostctl_gate.sv
module test_hostctl_gate;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_collision = 1'b0, tx_success = 1'b0, tx_underflow = 1'b0;
    logic       rx_frame_kept = 1'b0, dma_tc = 1'b0;
    logic       irq, drq, fcs_corrupt, soft_reset;
    logic [1:0] buf_ctl;

    int nvec = 0, nfail = 0, cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostctl_gate i_hostctl_gate (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_collision(tx_collision), .tx_success(tx_success),
        .tx_underflow(tx_underflow), .rx_frame_kept(rx_frame_kept),
        .dma_tc(dma_tc), .irq(irq), .drq(drq), .buf_ctl(buf_ctl),
        .fcs_corrupt(fcs_corrupt), .soft_reset(soft_reset)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %02h expected %02h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // kind: 0 collision, 1 success, 2 underflow, 3 frame kept, 4 terminal count
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: tx_collision = 1'b1;
            1: tx_success = 1'b1;
            2: tx_underflow = 1'b1;
            3: rx_frame_kept = 1'b1;
            default: dma_tc = 1'b1;
        endcase
        @(negedge clk);
        tx_collision = 1'b0; tx_success = 1'b0; tx_underflow = 1'b0;
        rx_frame_kept = 1'b0; dma_tc = 1'b0;
    endtask

    task automatic soft_rst();
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h00);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd0, v); chk("R6 reset ctrl", v, 8'h80);
        rd(2'd1, v); chk("R4 reset txstat", v, 8'h00);
        chk("R2 reset irq/drq", {6'b0, irq, drq}, 8'h00);

        // main sweep: mask x outcome x enable
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 16; m++) begin
                for (int k = 0; k < 3; k++) begin
                    soft_rst();
                    wr(2'd0, 8'((en << 6) | 8'h04));
                    wr(2'd1, 8'(m));
                    pulse(k == 0 ? 0 : (k == 1 ? 1 : 2));
                    st = (k == 0) ? 8'h02 : (k == 1 ? 8'h08 : 8'h01);
                    chk("R9 R2 R12 irq after outcome", {7'b0, irq},
                        8'(en & ((st & 8'(m)) != 0)));
                    rd(2'd0, v);
                    if (k == 1) chk("R7 rollover ctrl", v, 8'(8'h80 | (en << 6) | 8'h08 | 8'h01));
                    else        chk("R6 busy drop ctrl", v, 8'((en << 6) | 8'h04));
                    rd(2'd1, v); chk("R4 outcome byte", v, st);
                    chk("R9 read clears irq", {7'b0, irq}, 8'h00);
                end
            end
        end

        // R10: events ignored in host mode
        soft_rst();
        wr(2'd0, 8'h40); wr(2'd1, 8'h0F);
        pulse(0); pulse(1);
        chk("R10 irq in host", {7'b0, irq}, 8'h00);
        rd(2'd1, v); chk("R10 txstat in host", v, 8'h00);

        // R5: collision run, success clears count
        soft_rst();
        wr(2'd0, 8'h44); wr(2'd1, 8'h04);
        for (int k = 1; k <= 17; k++) begin
            pulse(0);
            chk("R5 irq on 16th", {7'b0, irq}, 8'(k == 16));
            rd(2'd1, v); chk("R5 collision byte", v, (k == 16) ? 8'h06 : 8'h02);
            wr(2'd0, 8'h40); wr(2'd0, 8'h44);
        end
        pulse(1);
        rd(2'd1, v); chk("R5 success byte", v, 8'h08);
        wr(2'd0, 8'h44);
        for (int k = 1; k <= 16; k++) begin
            pulse(0);
            rd(2'd1, v); chk("R5 count restarted", v, (k == 16) ? 8'h06 : 8'h02);
            wr(2'd0, 8'h40); wr(2'd0, 8'h44);
        end

        // R6: loopback success clears transmit busy without rollover
        soft_rst();
        wr(2'd0, 8'h4C);
        rd(2'd0, v); chk("R8 loop armed", v, 8'hCD);
        pulse(1);
        rd(2'd0, v); chk("R6 loop done", v, 8'h4D);
        chk("R11 buf_ctl loop", {6'b0, buf_ctl}, 8'h03);

        // R8: receive path
        soft_rst();
        wr(2'd0, 8'h48);
        rd(2'd0, v); chk("R8 armed", v, 8'hC9);
        pulse(3);
        rd(2'd0, v); chk("R8 busy falls", v, 8'hC8);
        chk("R8 R12 rx irq", {7'b0, irq}, 8'h01);
        rd(2'd2, v); chk("R8 ack reads pending", v, 8'h01);
        chk("R8 irq cleared", {7'b0, irq}, 8'h00);
        rd(2'd2, v); chk("R8 pending gone", v, 8'h00);

        // R3: DMA with enable
        soft_rst();
        wr(2'd0, 8'h60);
        chk("R3 drq asserted", {7'b0, drq}, 8'h01);
        pulse(4);
        chk("R3 drq drops, irq", {6'b0, irq, drq}, 8'h02);
        rd(2'd0, v); chk("R3 done bit", v, 8'hF0);
        wr(2'd0, 8'h40);
        chk("R3 clear request", {6'b0, irq, drq}, 8'h00);
        rd(2'd0, v); chk("R3 done cleared", v, 8'hC0);

        // R2: DMA completes with enable off
        wr(2'd0, 8'h20);
        chk("R2 drq gated", {7'b0, drq}, 8'h00);
        pulse(4);
        chk("R2 irq gated", {7'b0, irq}, 8'h00);
        rd(2'd0, v); chk("R2 done still set", v, 8'hB0);
        wr(2'd0, 8'h60);
        chk("R12 enable exposes done", {6'b0, irq, drq}, 8'h02);

        // R11: bad FCS control
        wr(2'd0, 8'h01);
        chk("R11 fcs on", {7'b0, fcs_corrupt}, 8'h01);
        wr(2'd0, 8'h00);
        chk("R11 fcs off", {7'b0, fcs_corrupt}, 8'h00);

        // R1: reset hold
        wr(2'd0, 8'h6D); wr(2'd1, 8'h0F);
        wr(2'd0, 8'h80);
        chk("R1 hold output", {7'b0, soft_reset}, 8'h01);
        rd(2'd0, v); chk("R1 ctrl in hold", v, 8'h80);
        chk("R1 quiet lines", {6'b0, irq, drq}, 8'h00);
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h44);
        rd(2'd0, v); chk("R1 release discarded", v, 8'h80);
        wr(2'd0, 8'h44);
        pulse(0);
        chk("R1 mask was cleared", {7'b0, irq}, 8'h00);
        rd(2'd1, v); chk("R1 status live again", v, 8'h02);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule